// File: doc/BRIEF.md
# Serial Channel Immediate Transfer Controller

This block is a register-mapped serial master for one channel. Software picks a target device and a serial clock rate in a control word. It then writes a command word that starts a transfer of one, two or four bytes, either outbound or inbound. The block shifts the bytes over a clock/data-out/data-in link and drives one of three active-low selects. Software learns that the transfer is over when the start bit it wrote reads back as zero.

All payload sits left-justified in a 32-bit data word. Outbound bits leave from bit 31 downward. Inbound bits are packed into the top of the word in arrival order, and the unused low bytes are cleared. A typical presence probe sends a 16-bit zero command and then reads 32 bits back. An all-zeros or all-ones reply means no device is present.

Top module: `serial_xfer_ctrl`

## Requirements
- R1: After reset, every register reads 0, all three selects are high (`sel_n` = 3'b111) and `sclk` is low.
- R2: The control word at offset 0x00 holds the select field in bits 9:7 and reads back. `sel_n[n]` is low exactly when bit 7+n is 1, and a zero field leaves all selects high.
- R3: The rate code in control bits 6:4 is captured when a transfer starts. It gives an `sclk` period of 2^(code+1) system clocks, with high and low halves equal.
- R4: In the command word at offset 0x0C, bit 0 starts a transfer, bits 3:2 give the direction (0 = read, any other value = write) and bits 5:4 give bytes minus one. Bit 0 reads 1 from the edge that starts the transfer. It reads 0 again from the edge of the last falling `sclk`, which comes 2^(code+1) x 8 x bytes clocks after the start. Bits 5:2 read back as written.
- R5: Bits go out MSB first, starting from bit 31 of the data word. `mosi` changes only where `sclk` falls and stays stable while `sclk` is high. `miso` is sampled at each rising `sclk`.
- R6: On a read, the data word at offset 0x10 is loaded, at the completing edge, with the received bits placed from bit 31 downward in arrival order. Every bit below them is 0.
- R7: A write transfer leaves the data word unchanged.
- R8: While a transfer runs, writes to the command word and to the data word are ignored. Length, direction and data keep their values.
- R9: `sclk` is low whenever no transfer is in progress.
- R10: Offsets other than 0x00, 0x0C and 0x10 read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 3 | Active-low device selects |

## Verification
The bound checker watches four things on every cycle: the serial clock stays low while idle, outbound data holds while the clock is high, completion coincides with a falling clock, and length and direction stay frozen during a transfer. It also confirms that a write transfer never alters the data word. Some behaviour only the bench scenarios can show. These are the exact completion time for each rate code and length, the left-justified packing and zero fill of received bytes, the rejection of commands and data issued mid-transfer, and the select decoding. The bench shows them by comparing the pins against a timing model on every clock and by reading the registers back after each case.

// File: rtl/sxc_pkg.sv
// Package: register offsets and field positions shared by the controller.
// Assumes a 32-bit register word and byte offsets on a 5-bit address.
package sxc_pkg;
    localparam int ADDR_W   = 5;
    localparam logic [ADDR_W-1:0] OFF_CTL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CMD  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_DATA = 5'h10;
    localparam int SEL_LSB  = 7;
    localparam int RATE_LSB = 4;
    localparam int START_BIT = 0;
    localparam int DIR_LSB  = 2;
    localparam int LEN_LSB  = 4;
    localparam int BYTE_W   = 8;
endpackage

// File: rtl/sxc_clkgen.sv
// Half-period tick generator. It pulses `tick` every 2^code cycles while
// `run` is high and restarts from zero whenever `run` is low.
// Assumes `code` stays stable for the whole of a run.
module sxc_clkgen #(
    parameter int RATE_W = 3,
    localparam int CNT_W = (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] code,
    output logic              tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   half_m1;

    // terminal count of one half period
    always_comb half_m1 = ({{CNT_W{1'b0}}, 1'b1} << code) - 1'b1;

    assign tick = run && (cnt == half_m1[CNT_W-1:0]);

    // count system clocks inside the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sxc_shifter.sv
// Bit engine. On `start` it loads a left-justified word and shifts `nbits`
// bits MSB first. sclk rises on odd ticks, where miso is captured, and falls
// on even ticks, where mosi advances. `finish` flags the edge of the last fall.
// Assumes 1 <= nbits <= DATA_W and no `start` while busy.
module sxc_shifter #(
    parameter int DATA_W = 32,
    localparam int NB_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [NB_W-1:0]   nbits,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] rxacc;
    logic [NB_W-1:0]   left;
    logic [NB_W-1:0]   nb_q;

    assign mosi    = sh[DATA_W-1];
    assign finish  = busy && tick && sclk && (left == NB_W'(1));
    assign rx_word = rxacc << (NB_W'(DATA_W) - nb_q);

    // serial state: load, clock phase, shift and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0; rxacc <= '0; left <= '0; nb_q <= NB_W'(DATA_W);
            sclk <= 1'b0; busy <= 1'b0;
        end else if (start) begin
            sh <= tx_word; rxacc <= '0; left <= nbits; nb_q <= nbits;
            sclk <= 1'b0; busy <= 1'b1;
        end else if (busy && tick) begin
            if (!sclk) begin
                sclk  <= 1'b1;
                rxacc <= {rxacc[DATA_W-2:0], miso};
            end else begin
                sclk <= 1'b0;
                sh   <= sh << 1;
                left <= left - 1'b1;
                if (left == NB_W'(1)) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_xfer_ctrl.sv
// Register-mapped single-channel serial master. It holds the control,
// command and data registers, drives the selects from the control word,
// and runs the tick generator and bit engine for immediate transfers.
// Assumes one register write per cycle and a combinational read path.
module serial_xfer_ctrl #(
    parameter int DATA_W = 32,
    parameter int RATE_W = 3,
    parameter int NDEV   = 3,
    localparam int ADDR_W = sxc_pkg::ADDR_W,
    localparam int NB_W   = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NDEV-1:0]   sel_n
);
    import sxc_pkg::*;

    logic [NDEV-1:0]   sel_q;
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] rate_run;
    logic              dir_wr_q;
    logic [1:0]        len_q;
    logic [1:0]        dir_q;
    logic [DATA_W-1:0] data_q;
    logic              busy, finish, tick, start;
    logic [DATA_W-1:0] rx_word;
    logic [NB_W-1:0]   start_bits;
    logic [1:0]        len_in;

    assign len_in     = reg_wdata[LEN_LSB +: 2];
    assign start_bits = NB_W'((int'(len_in) + 1) * BYTE_W);
    assign start      = reg_wen && (reg_addr == OFF_CMD) && !busy
                        && reg_wdata[START_BIT];
    assign sel_n      = ~sel_q;
    assign dir_wr_q   = (dir_q != 2'd0);

    // control word: select field and rate code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0; rate_q <= '0;
        end else if (reg_wen && reg_addr == OFF_CTL) begin
            sel_q  <= reg_wdata[SEL_LSB +: NDEV];
            rate_q <= reg_wdata[RATE_LSB +: RATE_W];
        end
    end

    // command fields, accepted only while idle; rate frozen at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0; len_q <= '0; rate_run <= '0;
        end else if (reg_wen && reg_addr == OFF_CMD && !busy) begin
            dir_q <= reg_wdata[DIR_LSB +: 2];
            len_q <= len_in;
            if (reg_wdata[START_BIT]) rate_run <= rate_q;
        end
    end

    // data word: software writes while idle, receive result on completion
    always_ff @(posedge clk) begin
        if (!rst_n)                                         data_q <= '0;
        else if (finish && !dir_wr_q)                       data_q <= rx_word;
        else if (reg_wen && reg_addr == OFF_DATA && !busy)  data_q <= reg_wdata;
    end

    // register read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTL: begin
                reg_rdata[SEL_LSB +: NDEV]    = sel_q;
                reg_rdata[RATE_LSB +: RATE_W] = rate_q;
            end
            OFF_CMD: begin
                reg_rdata[START_BIT]     = busy;
                reg_rdata[DIR_LSB +: 2]  = dir_q;
                reg_rdata[LEN_LSB +: 2]  = len_q;
            end
            OFF_DATA: reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end

    sxc_clkgen #(.RATE_W(RATE_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(busy), .code(rate_run), .tick(tick)
    );

    sxc_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(data_q),
        .nbits(start_bits), .tick(tick), .miso(miso), .sclk(sclk),
        .mosi(mosi), .busy(busy), .finish(finish), .rx_word(rx_word)
    );
endmodule

// File: rtl/sxc_checker.sv
// Checker for serial_xfer_ctrl: serial timing and register hold properties.
// Assumes it is bound into the top module, where it sees internal state.
module sxc_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sclk,
    input logic              mosi,
    input logic              dir_wr,
    input logic [1:0]        len,
    input logic [DATA_W-1:0] data
);
    // R9: serial clock parked low while idle
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R5: outbound bit holds through the high half of sclk
    a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk) |=> (!sclk || $stable(mosi)));

    // R4: completion lands on a falling sclk
    a_r4_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(sclk));

    // R8: length and direction frozen during a transfer
    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(len) && $stable(dir_wr)));

    // R7: write transfer leaves data word untouched at completion
    a_r7_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && dir_wr) |-> $stable(data));
endmodule

bind serial_xfer_ctrl sxc_checker #(.DATA_W(DATA_W)) u_sxc_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .mosi(mosi),
    .dir_wr(dir_wr_q), .len(len_q), .data(data_q)
);

// File: tb/serial_xfer_ctrl_test.sv
// Bench: behavioural timing model compared on every clock, plus
// register scenarios. The device side replies from `reply`, MSB first.
module serial_xfer_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [2:0]  sel_n;

    int total = 0;
    int bad = 0;
    int rises = 0;
    int base = 0;
    logic [31:0] reply = '0;
    logic [4:0]  bit_idx;

    always #5 clk = ~clk;

    always @(posedge sclk) rises <= rises + 1;
    assign bit_idx = 5'(31 - (rises - base));
    assign miso = reply[bit_idx];

    serial_xfer_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .sel_n(sel_n)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: elapsed-time view of a transfer
    bit          m_busy = 0;
    bit          m_wr = 0;
    int          m_t = 0, m_h = 1, m_n = 8;
    logic [2:0]  m_sel = '0, m_rate = '0;
    logic [1:0]  m_len = '0, m_dir = '0;
    logic [31:0] m_data = '0, m_tx = '0, m_rx = '0;

    always @(posedge clk) begin
        bit pre;
        if (!rst_n) begin
            m_busy = 0; m_sel = '0; m_rate = '0; m_len = '0; m_dir = '0;
            m_data = '0; m_wr = 0;
        end else begin
            pre = m_busy;
            if (pre) begin
                m_t++;
                if ((m_t % m_h) == 0 && ((m_t / m_h) % 2) == 1)
                    m_rx = {m_rx[30:0], miso};
                if (m_t == 2 * m_h * m_n) begin
                    m_busy = 0;
                    if (!m_wr) m_data = m_rx << (32 - m_n);
                end
            end
            if (reg_wen) begin
                if (reg_addr == 5'h00) begin
                    m_sel = reg_wdata[9:7]; m_rate = reg_wdata[6:4];
                end else if (reg_addr == 5'h0C && !pre) begin
                    m_dir = reg_wdata[3:2]; m_wr = (reg_wdata[3:2] != 0);
                    m_len = reg_wdata[5:4];
                    if (reg_wdata[0]) begin
                        m_busy = 1; m_t = 0; m_rx = '0;
                        m_h = 1 << m_rate; m_n = (int'(m_len) + 1) * 8;
                        m_tx = m_data;
                    end
                end else if (reg_addr == 5'h10 && !pre) begin
                    m_data = reg_wdata;
                end
            end
        end
    end

    // per-clock pin comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_sclk;
            exp_sclk = m_busy ? (((m_t / m_h) % 2) == 1) : 1'b0;
            chk(sclk == exp_sclk, "R3/R9 sclk", 32'(sclk), 32'(exp_sclk));
            chk(sel_n == ~m_sel, "R2 sel_n", 32'(sel_n), 32'(~m_sel));
            if (m_busy)
                chk(mosi == m_tx[31 - m_t / (2 * m_h)], "R5 mosi",
                    32'(mosi), 32'(m_tx[31 - m_t / (2 * m_h)]));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    // poll the start bit; expk < 0 skips the cycle-count check
    task automatic wait_idle(input int expk, input string tag);
        int k = 0;
        forever begin
            reg_addr = 5'h0C;
            #1;
            if (!reg_rdata[0]) break;
            @(negedge clk);
            k++;
        end
        if (expk >= 0) chk(k == expk, tag, 32'(k), 32'(expk));
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(5'h00, 32'h0, "R1 ctl reset");
        rd(5'h0C, 32'h0, "R1 cmd reset");
        rd(5'h10, 32'h0, "R1 data reset");
        chk(sel_n == 3'b111, "R1 sel_n reset", 32'(sel_n), 32'h7);
        chk(sclk == 1'b0, "R1 sclk reset", 32'(sclk), 32'h0);

        // R2: select device 1, rate 0
        wr(5'h00, 32'h0000_0100);
        rd(5'h00, 32'h0000_0100, "R2 ctl readback");
        chk(sel_n == 3'b101, "R2 sel dev1", 32'(sel_n), 32'h5);

        // R4 R5 R7: one-byte write at rate 0 -> 16 clocks
        wr(5'h10, 32'hC300_0000);
        wr(5'h0C, 32'h0000_0005);
        rd(5'h0C, 32'h0000_0005, "R4 start reads 1 while busy");
        wait_idle(15, "R4 one-byte write length");
        rd(5'h10, 32'hC300_0000, "R7 write keeps data");
        rd(5'h0C, 32'h0000_0004, "R4 cmd fields after write");

        // probe: 16-bit zero command then 32-bit read at rate 1
        wr(5'h00, 32'h0000_0090);
        chk(sel_n == 3'b110, "R2 sel dev0", 32'(sel_n), 32'h6);
        wr(5'h10, 32'h0);
        wr(5'h0C, 32'h0000_0015);
        wait_idle(64, "R3 rate1 two-byte time");
        reply = 32'h1234_5678; base = rises;
        wr(5'h0C, 32'h0000_0031);
        wait_idle(128, "R4 rate1 four-byte time");
        rd(5'h10, 32'h1234_5678, "R6 four-byte read");
        rd(5'h0C, 32'h0000_0030, "R4 cmd fields after read");

        // R3 R6: rate 2, two-byte read, low half zeroed
        wr(5'h00, 32'h0000_0120);
        reply = 32'hBEEF_1234; base = rises;
        wr(5'h0C, 32'h0000_0011);
        wait_idle(128, "R3 rate2 two-byte time");
        rd(5'h10, 32'hBEEF_0000, "R6 two-byte left justified");

        // R8: command and data writes ignored mid-transfer
        wr(5'h00, 32'h0000_0200);
        chk(sel_n == 3'b011, "R2 sel dev2", 32'(sel_n), 32'h3);
        reply = 32'h5A00_0000; base = rises;
        wr(5'h0C, 32'h0000_0001);
        wr(5'h0C, 32'h0000_0035);
        wr(5'h10, 32'hFFFF_FFFF);
        wait_idle(-1, "R8");
        rd(5'h0C, 32'h0000_0000, "R8 cmd unchanged");
        rd(5'h10, 32'h5A00_0000, "R8 data from transfer only");

        // R3: slowest code, one byte -> 2*128*8 clocks
        wr(5'h00, 32'h0000_0270);
        reply = 32'h8100_0000; base = rises;
        wr(5'h0C, 32'h0000_0001);
        wait_idle(2048, "R3 rate7 one-byte time");
        rd(5'h10, 32'h8100_0000, "R6 one-byte read");

        // R10: unmapped offsets
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h04, 32'h0, "R10 offset 4 reads zero");
        rd(5'h08, 32'h0, "R10 offset 8 reads zero");
        rd(5'h00, 32'h0000_0270, "R10 ctl untouched");
        rd(5'h10, 32'h8100_0000, "R10 data untouched");

        // R2: zero field releases all selects
        wr(5'h00, 32'h0);
        chk(sel_n == 3'b111, "R2 none selected", 32'(sel_n), 32'h7);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule